// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block carries out the four stack instructions of a small 8-bit processor core: stack-pointer reset, software interrupt, return from interrupt and return from subroutine. The surrounding core decodes the opcode and raises `start` together with its current program counter, accumulator, index register and condition codes. The sequencer then owns a byte-wide memory port and makes at most one memory transfer per clock. When it finishes, it presents the updated register values on its outputs.

The stack pointer is 8 bits wide and addresses a fixed 256-byte page, so it wraps modulo 256. A push writes at the stack pointer and then decrements it. A pull increments the stack pointer first and then reads. The software interrupt vector is a parameter. Its high byte sits at the vector address and its low byte at the next address. Every instruction has a fixed cycle budget. `done` pulses in its last cycle, and `busy` keeps further starts out until that cycle has passed.

Top module: `stack_seq`

## Requirements
- R1: Opcode 0x9C takes 2 cycles, makes no memory access and sets the stack pointer to 0xFF.
- R2: Opcode 0x83 first adds one to the captured PC. It then writes, one per cycle starting in cycle 2, PC low, PC high, X, A and CCR to addresses {page, SP}, {page, SP-1}, and so on. SP ends 5 lower.
- R3: After stacking, opcode 0x83 sets CCR bit 3 (interrupt mask) and leaves every other CCR bit as captured. It reads the new PC high byte from the vector address in cycle 8 and the low byte from vector address + 1 in cycle 9. The stacked CCR carries the mask bit as it was before the instruction.
- R4: Opcode 0x80 reads, one per cycle starting in cycle 2, from {page, SP+1} up to {page, SP+5}. The five bytes restore CCR (all 8 bits), A, X, PC high and PC low, in that order. SP ends 5 higher.
- R5: Opcode 0x81 reads PC high from {page, SP+1} in cycle 2 and PC low from {page, SP+2} in cycle 3. SP ends 2 higher, and A, X and CCR keep their captured values.
- R6: Counting the cycle in which `start` is accepted as cycle 1, `done` is high only in cycle 2, 10, 9 or 6 for opcodes 0x9C, 0x83, 0x80 and 0x81 respectively. `busy` is low again in the following cycle.
- R7: `busy` is high from cycle 2 through the `done` cycle. A `start` seen while `busy` is high is ignored, including one in the `done` cycle. A `start` with any other opcode is ignored and changes no output.
- R8: `mem_we` and `mem_re` are never high together, and neither is high in a cycle without a transfer.
- R9: After reset, `busy` and `done` are low, SP is 0xFF, and PC, A, X and CCR are zero.
- R10: The stack pointer wraps within the page: a push at SP = 0x00 is followed by one at 0xFF, and a pull at SP = 0xFF reads address offset 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the instruction in `opcode` |
| opcode | input | 8 | Stack instruction opcode |
| pc_in | input | 16 | PC value captured at start |
| a_in | input | 8 | Accumulator captured at start |
| x_in | input | 8 | Index register captured at start |
| ccr_in | input | 8 | Condition codes captured at start (bit 3 = I mask) |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Instruction in progress, cycles 2 to last |
| done | output | 1 | Last cycle of an instruction |
| sp_out | output | 8 | Stack pointer |
| pc_out | output | 16 | Program counter |
| a_out | output | 8 | Accumulator |
| x_out | output | 8 | Index register |
| ccr_out | output | 8 | Condition codes |

## Verification
Two events can fall in the same cycle: the `done` of one instruction and a fresh `start` request. The bench holds `start` high with a software-interrupt opcode through every cycle of a subroutine return, including its `done` cycle, and then keeps it high for one more cycle. The reference model accepts only the request in the cycle after `done`. A start taken any earlier shows up on the memory port as a misplaced write, and the per-cycle comparison flags it. The stack-pointer wrap and a push also coincide, when a software interrupt stacks across offset 0x00. The bench judges that case by the exact addresses and by the frame being pulled back intact.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [7:0]  STACK_PAGE = 8'h00,
  parameter logic [7:0]  SP_TOP     = 8'hFF,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] pc_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  ccr_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        busy,
  output logic        done,
  output logic [7:0]  sp_out,
  output logic [15:0] pc_out,
  output logic [7:0]  a_out,
  output logic [7:0]  x_out,
  output logic [7:0]  ccr_out
);
  localparam logic [7:0] OP_RSP = 8'h9C;
  localparam logic [7:0] OP_RTI = 8'h80;
  localparam logic [7:0] OP_RTS = 8'h81;
  localparam logic [7:0] OP_SWI = 8'h83;
  localparam int         IMASK  = 3;

  logic        busy_q;
  logic [7:0]  op_q, sp_q, a_q, x_q, ccr_q;
  logic [3:0]  step_q, last_step, slot;
  logic [15:0] pc_q;
  logic        known, accept, is_swi, is_rti, is_rts;
  logic        push_c, pull_c, vec_c;
  logic [7:0]  sp_inc;

  assign known  = (opcode == OP_RSP) || (opcode == OP_SWI) ||
                  (opcode == OP_RTI) || (opcode == OP_RTS);
  assign accept = start && !busy_q && known;
  assign is_swi = op_q == OP_SWI;
  assign is_rti = op_q == OP_RTI;
  assign is_rts = op_q == OP_RTS;

  always_comb begin
    case (op_q)
      OP_RSP:  last_step = 4'd2;
      OP_SWI:  last_step = 4'd10;
      OP_RTI:  last_step = 4'd9;
      default: last_step = 4'd6;
    endcase
  end

  assign done   = busy_q && (step_q == last_step);
  assign push_c = busy_q && is_swi && (step_q >= 4'd2) && (step_q <= 4'd6);
  assign pull_c = busy_q && ((is_rti && (step_q >= 4'd2) && (step_q <= 4'd6)) ||
                             (is_rts && (step_q >= 4'd2) && (step_q <= 4'd3)));
  assign vec_c  = busy_q && is_swi && ((step_q == 4'd8) || (step_q == 4'd9));
  assign sp_inc = sp_q + 8'd1;
  assign slot   = is_rts ? step_q + 4'd1 : step_q - 4'd2;

  always_comb begin
    case (step_q)
      4'd2:    mem_wdata = pc_q[7:0];
      4'd3:    mem_wdata = pc_q[15:8];
      4'd4:    mem_wdata = x_q;
      4'd5:    mem_wdata = a_q;
      default: mem_wdata = ccr_q;
    endcase
  end

  assign mem_addr = vec_c ? VEC_ADDR + {15'd0, step_q == 4'd9}
                          : {STACK_PAGE, pull_c ? sp_inc : sp_q};
  assign mem_we   = push_c;
  assign mem_re   = pull_c || vec_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= 8'h00;
      step_q <= 4'd0;
      sp_q   <= SP_TOP;
      pc_q   <= 16'h0000;
      a_q    <= 8'h00;
      x_q    <= 8'h00;
      ccr_q  <= 8'h00;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= opcode;
      step_q <= 4'd2;
      pc_q   <= (opcode == OP_SWI) ? pc_in + 16'd1 : pc_in;
      a_q    <= a_in;
      x_q    <= x_in;
      ccr_q  <= ccr_in;
    end else if (busy_q) begin
      step_q <= step_q + 4'd1;
      if (done) busy_q <= 1'b0;
      if (push_c) sp_q <= sp_q - 8'd1;
      if (pull_c) begin
        sp_q <= sp_inc;
        case (slot)
          4'd0:    ccr_q      <= mem_rdata;
          4'd1:    a_q        <= mem_rdata;
          4'd2:    x_q        <= mem_rdata;
          4'd3:    pc_q[15:8] <= mem_rdata;
          default: pc_q[7:0]  <= mem_rdata;
        endcase
      end
      if (is_swi && step_q == 4'd7) ccr_q[IMASK] <= 1'b1;
      if (vec_c && step_q == 4'd8) pc_q[15:8] <= mem_rdata;
      if (vec_c && step_q == 4'd9) pc_q[7:0]  <= mem_rdata;
      if (op_q == OP_RSP && step_q == 4'd2) sp_q <= SP_TOP;
    end
  end

  assign busy    = busy_q;
  assign sp_out  = sp_q;
  assign pc_out  = pc_q;
  assign a_out   = a_q;
  assign x_out   = x_q;
  assign ccr_out = ccr_q;

  assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_q == $past(sp_q) - 8'd1);
  assert_pull_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pull_c |=> sp_q == $past(sp_q) + 8'd1);
  assert_rsp_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_RSP) |=> sp_q == SP_TOP);
  assert_swi_imask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_swi) |-> ccr_q[IMASK]);
  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q);
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> $stable(op_q));
endmodule

// File: tb/stack_seq_tb.sv
module stack_seq_tb_top;
  localparam logic [7:0] VH = 8'h56;
  localparam logic [7:0] VL = 8'h78;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opcode = 8'h00, a_in = 8'h00, x_in = 8'h00, ccr_in = 8'h00, mem_rdata;
  logic [15:0] pc_in = 16'h0000, mem_addr, pc_out;
  logic [7:0] mem_wdata, sp_out, a_out, x_out, ccr_out;
  logic mem_we, mem_re, busy, done;

  always #5 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
    .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .busy(busy), .done(done), .sp_out(sp_out), .pc_out(pc_out), .a_out(a_out),
    .x_out(x_out), .ccr_out(ccr_out));

  logic [7:0] stk [256];
  always_comb begin
    if (mem_addr[15:8] == 8'h00) mem_rdata = stk[mem_addr[7:0]];
    else if (mem_addr == 16'hFFFC) mem_rdata = VH;
    else if (mem_addr == 16'hFFFD) mem_rdata = VL;
    else mem_rdata = 8'hEE;
  end
  always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h00) stk[mem_addr[7:0]] <= mem_wdata;

  typedef struct { bit we; bit re; bit [15:0] addr; bit [7:0] wd; bit dn; string tag; } rec_t;
  rec_t q[$];
  bit [7:0] m_sp = 8'hFF, m_a, m_x, m_ccr, m_stk [256];
  bit [15:0] m_pc;
  bit busy_now;
  string reg_tag = "R9";
  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void add(bit we, bit re, bit [15:0] ad, bit [7:0] wd, string t);
    rec_t r;
    r.we = we; r.re = re; r.addr = ad; r.wd = wd; r.dn = 1'b0; r.tag = t;
    q.push_back(r);
  endfunction

  task automatic build(input bit [7:0] op);
    bit [7:0] v;
    case (op)
      8'h9C: begin add(0, 0, 0, 0, "R1"); m_sp = 8'hFF; reg_tag = "R1"; end
      8'h83: begin
        m_pc = m_pc + 16'd1;
        for (int i = 0; i < 5; i++) begin
          v = (i == 0) ? m_pc[7:0] : (i == 1) ? m_pc[15:8] : (i == 2) ? m_x :
              (i == 3) ? m_a : m_ccr;
          add(1, 0, {8'h00, m_sp}, v, "R2");
          m_stk[m_sp] = v;
          m_sp = m_sp - 8'd1;
        end
        add(0, 0, 0, 0, "R3");
        add(0, 1, 16'hFFFC, 0, "R3");
        add(0, 1, 16'hFFFD, 0, "R3");
        add(0, 0, 0, 0, "R6");
        m_ccr[3] = 1'b1;
        m_pc = {VH, VL};
        reg_tag = "R3";
      end
      8'h80: begin
        for (int i = 0; i < 5; i++) begin
          m_sp = m_sp + 8'd1;
          add(0, 1, {8'h00, m_sp}, 0, "R4");
          v = m_stk[m_sp];
          case (i)
            0: m_ccr = v;
            1: m_a = v;
            2: m_x = v;
            3: m_pc[15:8] = v;
            default: m_pc[7:0] = v;
          endcase
        end
        for (int i = 0; i < 3; i++) add(0, 0, 0, 0, "R6");
        reg_tag = "R4";
      end
      default: begin
        for (int i = 0; i < 2; i++) begin
          m_sp = m_sp + 8'd1;
          add(0, 1, {8'h00, m_sp}, 0, "R5");
          if (i == 0) m_pc[15:8] = m_stk[m_sp]; else m_pc[7:0] = m_stk[m_sp];
        end
        for (int i = 0; i < 3; i++) add(0, 0, 0, 0, "R6");
        reg_tag = "R5";
      end
    endcase
    q[q.size()-1].dn = 1'b1;
  endtask

  task automatic check();
    rec_t r;
    bit same;
    if (q.size() > 0) begin
      r = q.pop_front();
      busy_now = 1'b1;
      chk(busy === 1'b1, "R7", "busy", busy, 1);
      chk(done === r.dn, "R6", "done", done, r.dn);
      chk(mem_we === r.we && mem_re === r.re, "R8", "we/re", {mem_we, mem_re}, {r.we, r.re});
      if (r.we || r.re) chk(mem_addr === r.addr, r.tag, "addr", mem_addr, r.addr);
      if (r.we) chk(mem_wdata === r.wd, r.tag, "wdata", mem_wdata, r.wd);
    end else begin
      busy_now = 1'b0;
      chk(busy === 1'b0 && done === 1'b0, "R7", "idle busy/done", {busy, done}, 0);
      chk(mem_we === 1'b0 && mem_re === 1'b0, "R8", "idle access", {mem_we, mem_re}, 0);
      chk(sp_out === m_sp, reg_tag, "sp", sp_out, m_sp);
      chk(pc_out === m_pc, reg_tag, "pc", pc_out, m_pc);
      chk(a_out === m_a && x_out === m_x, reg_tag, "a/x", {a_out, x_out}, {m_a, m_x});
      chk(ccr_out === m_ccr, reg_tag, "ccr", ccr_out, m_ccr);
      same = 1'b1;
      for (int i = 0; i < 256; i++) if (stk[i] !== m_stk[i]) same = 1'b0;
      chk(same, "R2", "stack page contents", same, 1);
    end
  endtask

  task automatic cyc(input bit s, input bit [7:0] op, input bit [15:0] pc,
                     input bit [7:0] a, input bit [7:0] x, input bit [7:0] c);
    @(negedge clk);
    check();
    start = s; opcode = op; pc_in = pc; a_in = a; x_in = x; ccr_in = c;
    if (s && !busy_now && (op == 8'h9C || op == 8'h83 || op == 8'h80 || op == 8'h81)) begin
      m_pc = pc; m_a = a; m_x = x; m_ccr = c;
      build(op);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 16'h0BAD, 8'hA5, 8'h5A, 8'hC3);
  endtask

  task automatic run(input bit [7:0] op, input bit [15:0] pc,
                     input bit [7:0] a, input bit [7:0] x, input bit [7:0] c);
    cyc(1, op, pc, a, x, c);
    while (q.size() > 0) idle(1);
    idle(1);
  endtask

  task automatic poke(input bit [7:0] ad, input bit [7:0] v);
    stk[ad] = v;
    m_stk[ad] = v;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) poke(i[7:0], 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);                                   // R9 reset state
    run(8'h83, 16'h1234, 8'h11, 8'h22, 8'hE5); // R2 R3 R6
    run(8'h80, 16'h4444, 8'h00, 8'h00, 8'h00); // R4: every CCR bit back
    poke(8'h00, 8'hAB);
    poke(8'h01, 8'hCD);
    run(8'h9C, 16'h2000, 8'h01, 8'h02, 8'h03); // R1
    run(8'h81, 16'h3000, 8'h44, 8'h55, 8'h66); // R5, R10 pull across 0xFF
    chk(pc_out === 16'hABCD && sp_out === 8'h01, "R10", "pull wrap pc/sp",
        {pc_out, sp_out}, {16'hABCD, 8'h01});
    run(8'h83, 16'hFFFE, 8'h33, 8'h44, 8'h1F); // R10 push across 0x00
    chk(stk[8'hFF] === 8'h44 && stk[8'h00] === 8'hFF, "R10", "push wrap bytes",
        {stk[8'hFF], stk[8'h00]}, {8'h44, 8'hFF});
    run(8'h80, 16'h0000, 8'h00, 8'h00, 8'h00);
    chk(pc_out === 16'hFFFF && sp_out === 8'h01 && ccr_out === 8'h1F, "R10",
        "frame back after wrap", {pc_out, sp_out, ccr_out}, {16'hFFFF, 8'h01, 8'h1F});
    cyc(1, 8'h42, 16'h7777, 8'h77, 8'h77, 8'h77); // R7 unknown opcode ignored
    idle(3);
    poke(8'h02, 8'h12);
    poke(8'h03, 8'h34);
    cyc(1, 8'h81, 16'h5000, 8'h9A, 8'hBC, 8'hDE); // R7 start held while busy
    while (q.size() > 0) cyc(1, 8'h83, 16'h6000, 8'h01, 8'h02, 8'h08);
    cyc(1, 8'h83, 16'h6000, 8'h01, 8'h02, 8'h08); // accepted right after done
    while (q.size() > 0) idle(1);
    idle(1);
    run(8'h9C, 16'h0100, 8'h0F, 8'hF0, 8'hAA); // R1 final
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule